// File: doc/BRIEF.md
# I2C Transmit Double-Buffer Controller

This block sits between a CPU-written transmit holding register and the transmit shift register of an I2C-style serial port. It holds the byte that software writes. It decides the cycle in which that byte moves into the shift register. It also keeps an internal "ready for next byte" flag that software cannot read. Bus events drive the flag: start, stop, the end of the ninth clock and the acknowledge value. Data writes, the transmit/receive select and the module enable drive it too.

All bus events arrive as single-cycle pulses that are already synchronous to the system clock. The block answers each pulse with a one-cycle load strobe and the byte to shift. The strobe and the byte are registered, so they appear one cycle after the event. A write that arrives once the shifter is already free goes straight to the shifter. Otherwise the byte waits in the holding register until the current byte completes. Pin driving and bit shifting are handled elsewhere.

Top module: `i2c_txbuf_ctrl`

## Requirements
- R1: After reset the ready flag is 0. In any cycle with the enable input low, the next cycle shows ready = 0 and no load strobe. This holds whatever other inputs are active.
- R2: A start pulse with the block enabled and no stop pulse sets ready to 1 in the next cycle. It also marks the shifter as free.
- R3: In transmit mode, a data write while the shifter is busy clears ready to 0 in the next cycle and gives no load strobe. The shifter is busy when no start was seen, no completed byte is pending and no byte completes in the same cycle.
- R4: A byte-complete pulse that is accepted while ready is 0 gives a load strobe in the next cycle. The load byte is the held byte and ready becomes 1.
- R5: A transmit-mode write while the shifter is free gives a load strobe carrying the written byte in the next cycle, and ready stays 1. The shifter is free after a start, or after a byte completed with ready at 1.
- R6: A stop pulse clears ready to 0 and marks the shifter busy. The next cycle shows no load strobe, and a later write only fills the holding register.
- R7: Acknowledge checking applies only when i2c_mode = 1 and ack_chk_en = 1. In that case a byte-complete pulse with ack_bit = 1 is ignored: no load strobe, and ready is unchanged. When checking does not apply, ack_bit has no effect.
- R8: With tx_mode = 0 (receive), a data write and a byte-complete pulse start no transfer and leave ready unchanged.
- R9: The enable going low and a stop pulse take priority over every other event. Among the remaining events, a write-triggered transfer ranks highest, so a write together with an accepted byte-complete loads the written byte.
- R10: The load strobe lasts one cycle and appears only when a transfer happens. Ready is 1 in every cycle that shows the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low clears the flag |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| i2c_mode | input | 1 | 1 = I2C format, 0 = clocked serial format |
| ack_chk_en | input | 1 | Acknowledge-bit checking enable |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_data | input | DW | Data written to the holding register |
| start_det | input | 1 | Start condition detected (pulse) |
| stop_det | input | 1 | Stop condition detected (pulse) |
| byte_done | input | 1 | Ninth-clock rising edge of a byte (pulse) |
| ack_bit | input | 1 | Acknowledge bit sampled with byte_done |
| load_pulse | output | 1 | One-cycle shift-register load strobe |
| load_data | output | DW | Byte to load into the shift register |
| ready | output | 1 | Internal ready-for-next-byte flag |

## Verification
A wrong internal state always shows at the ports within one cycle of the next event that reads it. A lost "shifter free" mark turns the next write into a plain fill: ready drops to 0 and no strobe appears, where a strobe was due. A stale free mark after a stop produces a load strobe that should not exist. A wrong acknowledge decision shows as a strobe and a change in ready on the cycle after the NACK, and a bad priority shows in the same way on the cycle after the clash. A held byte that was corrupted appears only on load_data, on the cycle after the next accepted byte-complete.

// File: rtl/i2c_txbuf_pkg.sv
package i2c_txbuf_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_KILL,
    ACT_WR_XFER,
    ACT_WR_FILL,
    ACT_DONE_XFER,
    ACT_DONE_IDLE,
    ACT_START
  } txb_act_e;

  // A completed byte counts unless acknowledge checking rejects it.
  function automatic logic ack_accepts(input logic i2c_fmt,
                                       input logic chk_en,
                                       input logic ack);
    return !(i2c_fmt && chk_en && ack);
  endfunction

endpackage

// File: rtl/txbuf_event_decode.sv
module txbuf_event_decode
  import i2c_txbuf_pkg::*;
(
  input  logic     enable,
  input  logic     tx_mode,
  input  logic     i2c_mode,
  input  logic     ack_chk_en,
  input  logic     wr_stb,
  input  logic     start_det,
  input  logic     stop_det,
  input  logic     byte_done,
  input  logic     ack_bit,
  input  logic     ready_q,
  input  logic     idle_q,
  output logic     done_ok,
  output logic     shifter_free,
  output txb_act_e act
);

  logic wr_tx;

  assign wr_tx        = wr_stb && tx_mode;
  assign done_ok      = tx_mode && byte_done && ack_accepts(i2c_mode, ack_chk_en, ack_bit);
  assign shifter_free = idle_q || done_ok || start_det;

  always_comb begin
    if (!enable || stop_det)       act = ACT_KILL;
    else if (wr_tx && shifter_free) act = ACT_WR_XFER;
    else if (wr_tx)                act = ACT_WR_FILL;
    else if (done_ok && !ready_q)  act = ACT_DONE_XFER;
    else if (done_ok)              act = ACT_DONE_IDLE;
    else if (start_det)            act = ACT_START;
    else                           act = ACT_NONE;
  end

endmodule

// File: rtl/txbuf_hold_reg.sv
module txbuf_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] hold_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (wr_en) hold_q <= wr_data;
  end

endmodule

// File: rtl/txbuf_flag_ctrl.sv
module txbuf_flag_ctrl
  import i2c_txbuf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  txb_act_e      act,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] hold_q,
  output logic          ready_q,
  output logic          idle_q,
  output logic          load_q,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      idle_q  <= 1'b0;
      load_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      load_q <= 1'b0;
      unique case (act)
        ACT_KILL, ACT_WR_FILL: begin
          ready_q <= 1'b0;
          idle_q  <= 1'b0;
        end
        ACT_WR_XFER: begin
          ready_q <= 1'b1;
          idle_q  <= 1'b0;
          load_q  <= 1'b1;
          data_q  <= wr_data;
        end
        ACT_DONE_XFER: begin
          ready_q <= 1'b1;
          idle_q  <= 1'b0;
          load_q  <= 1'b1;
          data_q  <= hold_q;
        end
        ACT_DONE_IDLE, ACT_START: begin
          ready_q <= 1'b1;
          idle_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_txbuf_ctrl.sv
module i2c_txbuf_ctrl
  import i2c_txbuf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tx_mode,
  input  logic          i2c_mode,
  input  logic          ack_chk_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          byte_done,
  input  logic          ack_bit,
  output logic          load_pulse,
  output logic [DW-1:0] load_data,
  output logic          ready
);

  txb_act_e      act;
  logic          done_ok;
  logic          shifter_free;
  logic          idle_q;
  logic [DW-1:0] hold_q;

  txbuf_event_decode u_dec (
    .enable       (enable),
    .tx_mode      (tx_mode),
    .i2c_mode     (i2c_mode),
    .ack_chk_en   (ack_chk_en),
    .wr_stb       (wr_stb),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .byte_done    (byte_done),
    .ack_bit      (ack_bit),
    .ready_q      (ready),
    .idle_q       (idle_q),
    .done_ok      (done_ok),
    .shifter_free (shifter_free),
    .act          (act)
  );

  txbuf_hold_reg #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (enable && wr_stb),
    .wr_data (wr_data),
    .hold_q  (hold_q)
  );

  txbuf_flag_ctrl #(.DW(DW)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .wr_data (wr_data),
    .hold_q  (hold_q),
    .ready_q (ready),
    .idle_q  (idle_q),
    .load_q  (load_pulse),
    .data_q  (load_data)
  );

endmodule

// File: rtl/i2c_txbuf_ctrl_chk.sv
module i2c_txbuf_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tx_mode,
  input logic i2c_mode,
  input logic ack_chk_en,
  input logic wr_stb,
  input logic start_det,
  input logic stop_det,
  input logic byte_done,
  input logic ack_bit,
  input logic shifter_free,
  input logic load_pulse,
  input logic ready
);

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ready && !load_pulse)); // R1

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_det && !stop_det) |=> ready); // R2

  AST_BUSY_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stop_det && tx_mode && wr_stb && !shifter_free) |=> (!ready && !load_pulse)); // R3

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop_det) |=> (!ready && !load_pulse)); // R6

  AST_NACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_mode && i2c_mode && ack_chk_en && byte_done && ack_bit
     && !wr_stb && !start_det && !stop_det) |=> (!load_pulse && ready == $past(ready))); // R7

  AST_RX_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |=> !load_pulse); // R8

  AST_LOAD_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> ready); // R10

endmodule

bind i2c_txbuf_ctrl i2c_txbuf_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .tx_mode      (tx_mode),
  .i2c_mode     (i2c_mode),
  .ack_chk_en   (ack_chk_en),
  .wr_stb       (wr_stb),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .byte_done    (byte_done),
  .ack_bit      (ack_bit),
  .shifter_free (shifter_free),
  .load_pulse   (load_pulse),
  .ready        (ready)
);

// File: tb/sim_i2c_txbuf_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_txbuf_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1, tx_mode = 1'b1, i2c_mode = 1'b1, ack_chk_en = 1'b1;
  logic       wr_stb = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic       byte_done = 1'b0, ack_bit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       load_pulse, ready;
  logic [7:0] load_data;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  i2c_txbuf_ctrl #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode),
    .i2c_mode(i2c_mode), .ack_chk_en(ack_chk_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .ack_bit(ack_bit), .load_pulse(load_pulse),
    .load_data(load_data), .ready(ready)
  );

  // Inputs are driven at a falling edge; one falling edge later the
  // registered response is visible. Strobes are then dropped.
  task automatic step(input logic wr, input logic [7:0] d, input logic st,
                      input logic sp, input logic dn, input logic ak);
    wr_stb = wr; wr_data = d; start_det = st; stop_det = sp;
    byte_done = dn; ack_bit = ak;
    @(negedge clk);
    wr_stb = 1'b0; start_det = 1'b0; stop_det = 1'b0;
    byte_done = 1'b0; ack_bit = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic exp_load,
                            input logic [7:0] exp_data, input logic exp_ready);
    total++;
    if (load_pulse !== exp_load || ready !== exp_ready ||
        (exp_load && load_data !== exp_data)) begin
      bad++;
      $display("FAIL %s: load=%b data=%h ready=%b expected load=%b data=%h ready=%b",
               req, load_pulse, load_data, ready, exp_load, exp_data, exp_ready);
    end
  endtask

  task automatic t_reset_and_fill;
    expect_out("R1 reset state", 1'b0, 8'h00, 1'b0);
    step(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 write with shifter busy", 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_start_and_first_byte;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 start sets ready", 1'b0, 8'h00, 1'b1);
    step(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R5 write after start loads at once", 1'b1, 8'hA5, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R10 strobe lasts one cycle", 1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_buffered_byte;
    step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 write while shifting clears ready", 1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R4 byte done moves held byte", 1'b1, 8'h3C, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R10 byte done with ready=1 gives no strobe", 1'b0, 8'h00, 1'b1);
    step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R5 write after completion loads at once", 1'b1, 8'h77, 1'b1);
  endtask

  task automatic t_ack_check;
    step(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 fill before nack", 1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R7 nack with checking ignored", 1'b0, 8'h00, 1'b0);
    i2c_mode = 1'b0;
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R7 serial mode ignores ack bit", 1'b1, 8'h11, 1'b1);
    i2c_mode = 1'b1;
  endtask

  task automatic t_receive_mode;
    tx_mode = 1'b0;
    step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R8 write in receive mode", 1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R8 byte done in receive mode", 1'b0, 8'h00, 1'b1);
    tx_mode = 1'b1;
  endtask

  task automatic t_priority_and_stop;
    step(1'b1, 8'h42, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R9 write with byte done loads written byte", 1'b1, 8'h42, 1'b1);
    step(1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R9 stop beats write", 1'b0, 8'h00, 1'b0);
    step(1'b1, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R6 write after stop only fills", 1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R9 stop beats start", 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_disable;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 start before disable", 1'b0, 8'h00, 1'b1);
    enable = 1'b0;
    step(1'b1, 8'h12, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_out("R1 disable clears flag over start/write", 1'b0, 8'h00, 1'b0);
    enable = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R4 held byte survives disable", 1'b1, 8'h66, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_fill();
    t_start_and_first_byte();
    t_buffered_byte();
    t_ack_check();
    t_receive_mode();
    t_priority_and_stop();
    t_disable();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule